// File: doc/BRIEF.md
# Transmit Buffer Space Request Generator

This block sits beside a byte-wide transmit buffer and tells the host when it may push more data. It keeps its own count of free byte slots: a host write lowers the count by one or two, depending on which byte lanes the write enables, and each byte that the MAC side drains raises it by one. A registered request output rises when the free space reaches a programmable threshold of 16, 32 or 64 bytes. The request is held low while transmission is disabled.

The host marks the last byte of a frame by pulling an active-low end-of-frame input during that write. The block stores a one-bit frame-end tag for every buffered byte, shows the tag of the oldest byte to the MAC side, and counts how many complete frames the buffer holds. A write that does not fit in the remaining space is refused and reported with a failure pulse. A write that is taken is reported with a done pulse. The data bytes themselves are stored outside this block.

Top module: `tx_xfer_req`

## Requirements
- R1: `tx_req` is registered. After each clock edge it equals the value, in the cycle before that edge, of (`tx_en` and free byte count >= selected threshold). It therefore drops one cycle after the free space falls below the threshold.
- R2: The `wm_sel` encoding is 2'b00 for 16 bytes and 2'b01 for 32 bytes. Both 2'b10 and 2'b11 select 64 bytes.
- R3: While `tx_en` is low, `tx_req` is low from the next cycle on, whatever the free space.
- R4: A host write needs the number of set bits in `host_be` as its byte count. A write with `host_be` = 2'b00 has no effect and produces neither `wr_done` nor `wr_fail`.
- R5: A write whose byte count exceeds the free count at that edge is refused and leaves the state unchanged. `wr_fail` pulses in the next cycle. An accepted write pulses `wr_done` in the next cycle instead. The full case and the one-free-byte/two-byte case are both refusals.
- R6: `mac_rd` drains one byte when the buffer is not empty. A drain on an empty buffer is ignored. A drain and a write in the same cycle both take effect, and the write is judged on the free count before the drain.
- R7: When `host_eof_n` is low on an accepted write, the last byte written carries the frame-end tag. For a two-lane write, the lane-0 byte is stored first and the lane-1 byte second. `head_eof` shows the tag of the oldest buffered byte.
- R8: `frames_held` rises by one on each accepted tagged write and falls by one when a tagged byte is drained. When both happen in the same cycle, it is unchanged.
- R9: After reset the free count equals DEPTH, and `tx_req`, `wr_done`, `wr_fail` and `frames_held` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 2 | Byte-lane enables of the write |
| host_eof_n | input | 1 | Active-low end-of-frame marker for the write |
| mac_rd | input | 1 | MAC-side drain of one byte |
| wm_sel | input | 2 | Threshold select: 00=16, 01=32, 1x=64 bytes |
| tx_en | input | 1 | Transmit enable; gates the request |
| tx_req | output | 1 | Request for more host data |
| wr_done | output | 1 | Pulse: previous write accepted |
| wr_fail | output | 1 | Pulse: previous write refused |
| head_eof | output | 1 | Frame-end tag of the oldest buffered byte |
| frames_held | output | $clog2(DEPTH+1) | Complete frames in the buffer |

## Verification
Each threshold setting is run through a full fill made of rotating one-lane and two-lane writes, followed by a full drain. This exposes an off-by-one or wrongly decoded threshold at the exact byte where the request changes, and it reaches the one-free-byte refusal. A fill with the enable cleared separates gating from the space compare. Mixed cycles that write and drain together show whether acceptance uses the count before the drain. Frame-end markers are placed at irregular intervals, and in both lanes, so that tag placement and the frame count are checked against the order of the drained bytes. Drains on an empty buffer and writes with no lanes enabled must leave every output unchanged.

// File: rtl/tx_req_pkg.sv
`timescale 1ns/1ps
package tx_req_pkg;

    typedef enum logic [1:0] {
        WM_16  = 2'b00,
        WM_32  = 2'b01,
        WM_64  = 2'b10,
        WM_64X = 2'b11
    } wm_sel_e;

    typedef struct packed {
        logic       acc;
        logic       rej;
        logic [1:0] nbytes;
    } wr_evt_t;

    function automatic int unsigned wm_bytes(input logic [1:0] sel);
        case (wm_sel_e'(sel))
            WM_16:   return 16;
            WM_32:   return 32;
            default: return 64;
        endcase
    endfunction

    function automatic logic [1:0] lane_count(input logic [1:0] be);
        return {1'b0, be[0]} + {1'b0, be[1]};
    endfunction

endpackage

// File: rtl/tx_space_ctr.sv
`timescale 1ns/1ps
module tx_space_ctr
    import tx_req_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [1:0]    be,
    input  logic          rd,
    output wr_evt_t       evt,
    output logic          rd_acc,
    output logic [CW-1:0] free
);

    logic [1:0] nb;

    always_comb begin
        nb         = lane_count(be);
        evt.nbytes = nb;
        evt.acc    = wr && (nb != 2'd0) && (CW'(nb) <= free);
        evt.rej    = wr && (nb != 2'd0) && !(CW'(nb) <= free);
        rd_acc     = rd && (free != CW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free <= CW'(DEPTH);
        end else begin
            free <= free - (evt.acc ? CW'(nb) : CW'(0)) + CW'(rd_acc);
        end
    end

    a_r6_free_bounded: assert property (@(posedge clk) disable iff (rst)
        free <= CW'(DEPTH));

    a_r5_reject_keeps_space: assert property (@(posedge clk) disable iff (rst)
        (wr && !rd && (CW'(lane_count(be)) > free)) |=> $stable(free));

    a_r6_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
        (free == CW'(DEPTH) && rd && !wr) |=> (free == CW'(DEPTH)));

    a_r4_no_lane_no_change: assert property (@(posedge clk) disable iff (rst)
        (be == 2'b00 && !rd) |=> $stable(free));

endmodule

// File: rtl/tx_tag_ring.sv
`timescale 1ns/1ps
module tx_tag_ring
    import tx_req_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_evt_t evt,
    input  logic    last,
    input  logic    rd_acc,
    output logic    head_tag
);

    logic [DEPTH-1:0] tags;
    logic [PW-1:0]    wp;
    logic [PW-1:0]    rp;
    logic [PW-1:0]    wp_nx;

    assign wp_nx    = wp + PW'(1);
    assign head_tag = tags[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            tags <= '0;
            wp   <= '0;
            rp   <= '0;
        end else begin
            if (evt.acc) begin
                if (evt.nbytes == 2'd2) begin
                    tags[wp]    <= 1'b0;
                    tags[wp_nx] <= last;
                end else begin
                    tags[wp] <= last;
                end
                wp <= wp + PW'(evt.nbytes);
            end
            if (rd_acc) begin
                rp <= rp + PW'(1);
            end
        end
    end

    a_r7_single_lane_tag: assert property (@(posedge clk) disable iff (rst)
        (evt.acc && evt.nbytes == 2'd1 && !rd_acc && wp == rp) |=> (head_tag == $past(last)));

endmodule

// File: rtl/tx_frame_ctr.sv
`timescale 1ns/1ps
module tx_frame_ctr #(
    parameter int DEPTH = 128,
    localparam int FW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [FW-1:0] frames
);

    always_ff @(posedge clk) begin
        if (rst) begin
            frames <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   frames <= frames + FW'(1);
                2'b01:   frames <= frames - FW'(1);
                default: frames <= frames;
            endcase
        end
    end

    a_r8_frames_bounded: assert property (@(posedge clk) disable iff (rst)
        frames <= FW'(DEPTH));

    a_r8_balanced_hold: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> $stable(frames));

endmodule

// File: rtl/tx_xfer_req.sv
`timescale 1ns/1ps
module tx_xfer_req
    import tx_req_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int FW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [1:0]    host_be,
    input  logic          host_eof_n,
    input  logic          mac_rd,
    input  logic [1:0]    wm_sel,
    input  logic          tx_en,
    output logic          tx_req,
    output logic          wr_done,
    output logic          wr_fail,
    output logic          head_eof,
    output logic [FW-1:0] frames_held
);

    wr_evt_t       evt;
    logic          rd_acc;
    logic [FW-1:0] free;
    logic [FW-1:0] thr;
    logic          last;

    assign thr  = FW'(wm_bytes(wm_sel));
    assign last = !host_eof_n;

    tx_space_ctr #(.DEPTH(DEPTH)) u_space (
        .clk   (clk),
        .rst   (rst),
        .wr    (host_wr),
        .be    (host_be),
        .rd    (mac_rd),
        .evt   (evt),
        .rd_acc(rd_acc),
        .free  (free)
    );

    tx_tag_ring #(.DEPTH(DEPTH)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .last    (last),
        .rd_acc  (rd_acc),
        .head_tag(head_eof)
    );

    tx_frame_ctr #(.DEPTH(DEPTH)) u_frames (
        .clk   (clk),
        .rst   (rst),
        .inc   (evt.acc && last),
        .dec   (rd_acc && head_eof),
        .frames(frames_held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_req  <= 1'b0;
            wr_done <= 1'b0;
            wr_fail <= 1'b0;
        end else begin
            tx_req  <= tx_en && (free >= thr);
            wr_done <= evt.acc;
            wr_fail <= evt.rej;
        end
    end

    a_r3_enable_gate: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !tx_req);

    a_r5_done_fail_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_done && wr_fail));

    a_r4_idle_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> (!wr_done && !wr_fail));

    a_r1_low_space_no_req: assert property (@(posedge clk) disable iff (rst)
        (free < FW'(16)) |=> !tx_req);

endmodule

// File: tb/tb_tx_xfer_req.sv
`timescale 1ns/1ps
module tb_tx_xfer_req;
    localparam int DEPTH = 128;
    localparam int FW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr = 1'b0;
    logic [1:0]    host_be = 2'b00;
    logic          host_eof_n = 1'b1;
    logic          mac_rd = 1'b0;
    logic [1:0]    wm_sel = 2'b00;
    logic          tx_en = 1'b0;
    logic          tx_req, wr_done, wr_fail, head_eof;
    logic [FW-1:0] frames_held;

    int checks = 0;
    int errors = 0;
    int mfree = DEPTH;
    int mframes = 0;
    int mwp = 0;
    int mrp = 0;
    logic mtag [DEPTH];

    always #2.5 clk = ~clk;

    tx_xfer_req #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_be(host_be),
        .host_eof_n(host_eof_n), .mac_rd(mac_rd), .wm_sel(wm_sel), .tx_en(tx_en),
        .tx_req(tx_req), .wr_done(wr_done), .wr_fail(wr_fail),
        .head_eof(head_eof), .frames_held(frames_held)
    );

    function automatic int thr_of(input logic [1:0] s);
        return (s == 2'b00) ? 16 : (s == 2'b01) ? 32 : 64;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic w, input logic [1:0] be, input logic eofn, input logic r);
        int n;
        bit acc, rej, racc, ereq, htag;
        host_wr = w; host_be = be; host_eof_n = eofn; mac_rd = r;
        n    = int'(be[0]) + int'(be[1]);
        acc  = w && n > 0 && n <= mfree;
        rej  = w && n > 0 && n > mfree;
        racc = r && mfree < DEPTH;
        ereq = tx_en && mfree >= thr_of(wm_sel);
        htag = mtag[mrp];
        @(posedge clk);
        #1;
        if (acc) begin
            if (n == 2) begin
                mtag[mwp] = 1'b0;
                mtag[(mwp + 1) % DEPTH] = !eofn;
            end else begin
                mtag[mwp] = !eofn;
            end
            mwp = (mwp + n) % DEPTH;
            mframes += int'(!eofn);
            mfree -= n;
        end
        if (racc) begin
            mrp = (mrp + 1) % DEPTH;
            mframes -= int'(htag);
            mfree += 1;
        end
        check(tx_req == ereq, tx_en ? "R1/R2 request" : "R3 gated request", int'(tx_req), int'(ereq));
        check(wr_done == acc, "R4/R5 done", int'(wr_done), int'(acc));
        check(wr_fail == rej, "R4/R5 fail", int'(wr_fail), int'(rej));
        check(int'(frames_held) == mframes, "R8 frames", int'(frames_held), mframes);
        if (mfree < DEPTH)
            check(head_eof == mtag[mrp], "R7/R6 head tag", int'(head_eof), int'(mtag[mrp]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] bep;
        for (int k = 0; k < DEPTH; k++) mtag[k] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R9 reset state
        check(tx_req == 1'b0, "R9 req", int'(tx_req), 0);
        check(wr_done == 1'b0 && wr_fail == 1'b0, "R9 pulses", int'({wr_done, wr_fail}), 0);
        check(frames_held == '0, "R9 frames", int'(frames_held), 0);
        tx_en = 1'b1;
        step(0, 2'b00, 1, 0);
        check(tx_req == 1'b1, "R9 free equals depth", int'(tx_req), 1);

        // R1 R2 sweep of every threshold: fill then drain
        for (int w = 0; w < 4; w++) begin
            wm_sel = 2'(w);
            for (int i = 0; i < 300 && mfree > 0; i++) begin
                bep = (i % 3 == 0) ? 2'b11 : (i % 3 == 1) ? 2'b01 : 2'b10;
                if (mfree == 1 && i % 2 == 0) bep = 2'b11; // R5 partial fit refusal
                step(1, bep, (i % 5 == 4) ? 1'b0 : 1'b1, 0);
            end
            step(1, 2'b01, 1, 0);           // R5 full refusal
            step(1, 2'b11, 0, 0);
            for (int j = 0; j < DEPTH + 2; j++) step(0, 2'b00, 1, 1);
        end

        // R3 enable gating during a fill
        tx_en = 1'b0; wm_sel = 2'b00;
        for (int i = 0; i < 40; i++) step(1, 2'b11, (i % 7 == 6) ? 1'b0 : 1'b1, 0);
        tx_en = 1'b1;
        for (int j = 0; j < 90; j++) step(0, 2'b00, 1, 1);

        // R6 simultaneous write and drain, R8 balanced counting
        wm_sel = 2'b01;
        for (int i = 0; i < 400; i++)
            step((i % 4) != 3, (i % 2 == 0) ? 2'b11 : 2'b10, (i % 3 == 2) ? 1'b0 : 1'b1, (i % 5) != 0);
        for (int j = 0; j < DEPTH + 2; j++) step(1, 2'b11, 0, 1);
        for (int j = 0; j < DEPTH + 2; j++) step(0, 2'b00, 1, 1);

        // R6 drains on empty, R4 writes with no lanes
        for (int i = 0; i < 4; i++) step(0, 2'b00, 1, 1);
        for (int i = 0; i < 4; i++) step(1, 2'b00, 0, 0);
        step(1, 2'b10, 0, 0);
        check(head_eof == 1'b1, "R7 lane-1 single tag", int'(head_eof), 1);
        step(0, 2'b00, 1, 1);
        step(0, 2'b00, 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule